// File: doc/BRIEF.md
# Three-Channel Match Timer Bank with Snapshot Capture

This block holds a bank of up-counting timers behind a simple word-addressed register bus. Each timer has its own count-enable bit, a set of equality comparators, a preload value and a reload selector. On every enabled cycle a timer either adds one to its count or, when the comparator chosen by its reload selector matches, loads the preload value. Every comparator match sets a sticky status bit. Status bits that are also enabled raise a single level interrupt.

A running count cannot be read directly. Software writes a capture request to the timer's snapshot word. A small state machine then spends two cycles bringing the count into a holding register, and a busy flag reads 1 for that time. Once the flag drops, software reads the held value from the same word. The value cannot tear while the counter keeps running.

The capture machine has three states: CAP_IDLE, CAP_SYNC and CAP_LATCH. In the transition *request*, a write with bit 0 set moves the machine from CAP_IDLE to CAP_SYNC. In *advance*, CAP_SYNC always moves to CAP_LATCH on the next cycle. In *commit*, CAP_LATCH loads the holding register and returns to CAP_IDLE. Busy reads 1 in CAP_SYNC and in CAP_LATCH.

Top module: `mtimer_bank`

## Requirements
- R1: The register word addresses are: enable 0, match 1..9, preload 10..12, reload select 13..15, status 16..18, interrupt enable 19..21, status clear 22..24, snapshot 25..27 and busy 28. After reset every register, counter, status bit and holding register is 0 and irq is low.
- R2: Match word 1 + 3*t + c holds comparator c of timer t. The comparator hits on an enabled cycle in which the count equals that value.
- R3: Reload-select word 13+t takes the value v. For v in 1..3, a hit on comparator v-1 loads the counter with preload word 10+t instead of incrementing it. For v = 0 no reload happens and the timer runs free.
- R4: Bit t of enable word 0 gates timer t. While the bit is 0 the count holds its value.
- R5: Writing a word with bit 0 = 1 to snapshot word 25+t starts a capture. Bit t of busy word 28 then reads 1 for exactly two cycles. After that, word 25+t returns the count as it stood at the end of the capture. A request made while busy, or one with bit 0 = 0, is ignored.
- R6: Without a reload, an enabled count goes up by 1 per cycle and wraps from 0xFFFFFFFF to 0.
- R7: A hit on comparator c sets bit c of status word 16+t, and the bit stays set. Writing 1 to bit c of clear word 22+t clears only that bit.
- R8: irq is high exactly when some status bit is 1 and the matching bit of interrupt-enable word 19+t is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every timer against every reload-select value, including the free-running value 0. For each case it predicts the final count and the set of comparators hit with an arithmetic model. A wrong comparator choice, or a reload that increments instead of loading, shows up as a different count or status. The preload sits just below the top of the count range, so a counter that saturates or fails to wrap gives a visibly wrong snapshot. A partial status clear must leave the other bits standing, and a bank that clears too widely loses them. The bench also checks the capture handshake. Busy must read 1 for exactly two cycles, and two back-to-back captures of a running timer must differ by exactly their spacing in cycles. A second request made while busy must not extend the busy period, and a request with bit 0 clear must not start a capture at all.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_SYNC  = 2'd1,
        CAP_LATCH = 2'd2
    } cap_state_e;

    function automatic int addr_en();
        return 0;
    endfunction
    function automatic int addr_match();
        return 1;
    endfunction
    function automatic int addr_pre(input int nt, input int nc);
        return 1 + nt * nc;
    endfunction
    function automatic int addr_sel(input int nt, input int nc);
        return addr_pre(nt, nc) + nt;
    endfunction
    function automatic int addr_stat(input int nt, input int nc);
        return addr_sel(nt, nc) + nt;
    endfunction
    function automatic int addr_ie(input int nt, input int nc);
        return addr_stat(nt, nc) + nt;
    endfunction
    function automatic int addr_clr(input int nt, input int nc);
        return addr_ie(nt, nc) + nt;
    endfunction
    function automatic int addr_cap(input int nt, input int nc);
        return addr_clr(nt, nc) + nt;
    endfunction
    function automatic int addr_busy(input int nt, input int nc);
        return addr_cap(nt, nc) + nt;
    endfunction

endpackage

// File: rtl/mtimer_regbank.sv
module mtimer_regbank
    import mtimer_pkg::*;
#(
    parameter int NT   = 3,
    parameter int NC   = 3,
    parameter int CW   = 32,
    parameter int SELW = 2,
    parameter int AW   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic [CW-1:0]                 wdata,
    output logic [NT-1:0]                 en_o,
    output logic [NT*NC-1:0][CW-1:0]      match_o,
    output logic [NT-1:0][CW-1:0]         preload_o,
    output logic [NT-1:0][SELW-1:0]       sel_o,
    output logic [NT-1:0][NC-1:0]         ie_o,
    output logic [NT-1:0][NC-1:0]         clr_o,
    output logic [NT-1:0]                 cap_req_o
);
    localparam int A_EN    = addr_en();
    localparam int A_MATCH = addr_match();
    localparam int A_PRE   = addr_pre(NT, NC);
    localparam int A_SEL   = addr_sel(NT, NC);
    localparam int A_IE    = addr_ie(NT, NC);
    localparam int A_CLR   = addr_clr(NT, NC);
    localparam int A_CAP   = addr_cap(NT, NC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o      <= '0;
            match_o   <= '0;
            preload_o <= '0;
            sel_o     <= '0;
            ie_o      <= '0;
        end else if (wr_en) begin
            if (int'(addr) == A_EN) en_o <= wdata[NT-1:0];
            for (int i = 0; i < NT*NC; i++)
                if (int'(addr) == A_MATCH + i) match_o[i] <= wdata;
            for (int t = 0; t < NT; t++) begin
                if (int'(addr) == A_PRE + t) preload_o[t] <= wdata;
                if (int'(addr) == A_SEL + t) sel_o[t]     <= wdata[SELW-1:0];
                if (int'(addr) == A_IE + t)  ie_o[t]      <= wdata[NC-1:0];
            end
        end
    end

    always_comb begin
        for (int t = 0; t < NT; t++) begin
            clr_o[t]     = (wr_en && int'(addr) == A_CLR + t) ? wdata[NC-1:0] : '0;
            cap_req_o[t] = wr_en && int'(addr) == A_CAP + t && wdata[0];
        end
    end

endmodule

// File: rtl/mtimer_channel.sv
module mtimer_channel #(
    parameter int NC   = 3,
    parameter int CW   = 32,
    parameter int SELW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [NC-1:0][CW-1:0] match,
    input  logic [CW-1:0]         preload,
    input  logic [SELW-1:0]       sel,
    input  logic [NC-1:0]         clr,
    output logic [CW-1:0]         count,
    output logic [NC-1:0]         status
);
    logic [NC-1:0] hit;
    logic [NC-1:0] pick;
    logic          reload;

    for (genvar c = 0; c < NC; c++) begin : g_cmp
        assign hit[c]  = en && (count == match[c]);
        assign pick[c] = hit[c] && (sel == SELW'(c + 1));
    end
    assign reload = |pick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            status <= '0;
        end else begin
            if (en) count <= reload ? preload : count + CW'(1);
            status <= (status & ~clr) | hit;
        end
    end

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> count == $past(count));
    assert_step_or_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !reload) |=> count == $past(count) + CW'(1));
    assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> count == $past(preload));
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !clr[0]) |=> status[0]);

endmodule

// File: rtl/mtimer_capture.sv
module mtimer_capture
    import mtimer_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [CW-1:0] count,
    output logic          busy_o,
    output logic [CW-1:0] snap_o
);
    cap_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CAP_IDLE:  if (req) state_nx = CAP_SYNC;
            CAP_SYNC:  state_nx = CAP_LATCH;
            CAP_LATCH: state_nx = CAP_IDLE;
            default:   state_nx = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  snap_o <= '0;
        else if (state == CAP_LATCH) snap_o <= count;
    end

    assign busy_o = (state != CAP_IDLE);

    assert_busy_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req) |=> busy_o);
    assert_busy_two_cycles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o) |=> !busy_o);
    assert_snap_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(snap_o));

endmodule

// File: rtl/mtimer_bank.sv
module mtimer_bank
    import mtimer_pkg::*;
#(
    parameter int NT = 3,
    parameter int NC = 3,
    parameter int CW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    output logic          irq
);
    localparam int SELW    = $clog2(NC + 1);
    localparam int A_EN    = addr_en();
    localparam int A_MATCH = addr_match();
    localparam int A_PRE   = addr_pre(NT, NC);
    localparam int A_SEL   = addr_sel(NT, NC);
    localparam int A_STAT  = addr_stat(NT, NC);
    localparam int A_IE    = addr_ie(NT, NC);
    localparam int A_CAP   = addr_cap(NT, NC);
    localparam int A_BUSY  = addr_busy(NT, NC);

    logic [NT-1:0]            en;
    logic [NT*NC-1:0][CW-1:0] match;
    logic [NT-1:0][CW-1:0]    preload;
    logic [NT-1:0][SELW-1:0]  sel;
    logic [NT-1:0][NC-1:0]    ie;
    logic [NT-1:0][NC-1:0]    clr;
    logic [NT-1:0]            cap_req;
    logic [NT-1:0][CW-1:0]    count;
    logic [NT-1:0][NC-1:0]    status;
    logic [NT-1:0][CW-1:0]    snap;
    logic [NT-1:0]            busy;

    mtimer_regbank #(.NT(NT), .NC(NC), .CW(CW), .SELW(SELW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .en_o(en), .match_o(match), .preload_o(preload), .sel_o(sel),
        .ie_o(ie), .clr_o(clr), .cap_req_o(cap_req)
    );

    for (genvar t = 0; t < NT; t++) begin : g_tmr
        mtimer_channel #(.NC(NC), .CW(CW), .SELW(SELW)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(en[t]),
            .match(match[t*NC +: NC]), .preload(preload[t]), .sel(sel[t]),
            .clr(clr[t]), .count(count[t]), .status(status[t])
        );
        mtimer_capture #(.CW(CW)) u_cap (
            .clk(clk), .rst_n(rst_n), .req(cap_req[t]), .count(count[t]),
            .busy_o(busy[t]), .snap_o(snap[t])
        );
    end

    assign irq = |(status & ie);

    always_comb begin
        rdata = '0;
        if (int'(addr) == A_EN)   rdata[NT-1:0] = en;
        if (int'(addr) == A_BUSY) rdata[NT-1:0] = busy;
        for (int i = 0; i < NT*NC; i++)
            if (int'(addr) == A_MATCH + i) rdata = match[i];
        for (int t = 0; t < NT; t++) begin
            if (int'(addr) == A_PRE + t)  rdata = preload[t];
            if (int'(addr) == A_SEL + t)  rdata[SELW-1:0] = sel[t];
            if (int'(addr) == A_STAT + t) rdata[NC-1:0] = status[t];
            if (int'(addr) == A_IE + t)   rdata[NC-1:0] = ie[t];
            if (int'(addr) == A_CAP + t)  rdata = snap[t];
        end
    end

    assert_no_status_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);
    assert_no_enable_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '0) |-> !irq);

endmodule

// File: tb/mtimer_bank_tb.sv
module mtimer_bank_tb;
    localparam int A_EN = 0, A_MATCH = 1, A_PRE = 10, A_SEL = 13, A_STAT = 16;
    localparam int A_IE = 19, A_CLR = 22, A_CAP = 25, A_BUSY = 28;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [5:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    mtimer_bank u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                       .wdata(wdata), .rdata(rdata), .irq(irq));

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        addr = 6'(a); wdata = d; wr_en = 1;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic idle(input int k);
        repeat (k) begin @(posedge clk); #1; end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = 6'(a); #1; d = rdata;
    endtask

    task automatic get_count(input int t, input bit chk, output logic [31:0] v);
        logic [31:0] b;
        wr(A_CAP + t, 1);
        rd(A_BUSY, b); if (chk) check("R5 busy first cycle", 32'(b[t]), 1);
        idle(1);
        rd(A_BUSY, b); if (chk) check("R5 busy second cycle", 32'(b[t]), 1);
        idle(1);
        rd(A_BUSY, b); if (chk) check("R5 busy released", 32'(b[t]), 0);
        rd(A_CAP + t, v);
    endtask

    initial begin
        logic [31:0] v, a0, b0, start, cnt, pre;
        logic [31:0] m [3];
        logic [2:0]  hits;
        logic [2:0]  iem;
        int          n;

        #25 rst_n = 1;
        @(posedge clk); #1;

        // R1 reset state
        rd(A_EN, v);      check("R1 enable reset", v, 0);
        rd(A_STAT, v);    check("R1 status reset", v, 0);
        rd(A_MATCH + 4, v); check("R1 match reset", v, 0);
        rd(A_BUSY, v);    check("R1 busy reset", v, 0);
        check("R1 irq reset", 32'(irq), 0);
        get_count(0, 1, v); check("R1 count reset", v, 0);

        // R2 R3 R4 R6 R7 R8 sweep: every timer, every reload selector
        for (int t = 0; t < 3; t++) begin
            for (int s = 0; s < 4; s++) begin
                get_count(t, 0, start);
                pre  = 32'hFFFF_FFFC - 32'(t);
                m[0] = start + 5;
                m[1] = start + 9;
                m[2] = start + 3;
                iem  = 3'b001 << ((t + s) % 3);
                for (int c = 0; c < 3; c++) wr(A_MATCH + 3*t + c, m[c]);
                wr(A_PRE + t, pre);
                wr(A_SEL + t, 32'(s));
                wr(A_IE + t, 32'(iem));
                wr(A_CLR + t, 32'h7);
                rd(A_STAT + t, v); check("R7 status cleared before run", v, 0);
                get_count((t + 1) % 3, 0, a0);
                n = 12 + 2*s + t;
                wr(A_EN, 32'(1 << t));
                idle(n - 1);
                wr(A_EN, 0);
                cnt = start; hits = 0;
                for (int i = 0; i < n; i++) begin
                    for (int c = 0; c < 3; c++) if (cnt == m[c]) hits[c] = 1'b1;
                    if (s >= 1 && cnt == m[s-1]) cnt = pre;
                    else cnt = cnt + 1;
                end
                get_count(t, 0, v);
                check($sformatf("R3 R6 count t%0d sel%0d", t, s), v, cnt);
                rd(A_STAT + t, v);
                check($sformatf("R2 R7 status t%0d sel%0d", t, s), v, 32'(hits));
                check($sformatf("R8 irq t%0d sel%0d", t, s), 32'(irq), 32'(|(hits & iem)));
                get_count((t + 1) % 3, 0, b0);
                check("R4 disabled timer holds", b0, a0);
                wr(A_CLR + t, 32'h2);
                rd(A_STAT + t, v);
                check("R7 partial clear", v, 32'(hits & 3'b101));
                wr(A_CLR + t, 32'h7);
                rd(A_STAT + t, v); check("R7 full clear", v, 0);
                check("R8 irq after clear", 32'(irq), 0);
            end
        end

        // R5 capture of a running timer, free running (R3 sel 0)
        wr(A_SEL + 0, 0);
        wr(A_EN, 1);
        get_count(0, 1, a0);
        get_count(0, 1, b0);
        check("R5 running capture spacing", b0 - a0, 3);
        wr(A_CAP + 0, 1);
        wr(A_CAP + 0, 1);
        idle(1);
        rd(A_BUSY, v); check("R5 request while busy ignored", 32'(v[0]), 0);
        wr(A_CAP + 1, 32'h2);
        rd(A_BUSY, v); check("R5 request with bit0 clear ignored", 32'(v[1]), 0);
        wr(A_EN, 0);
        get_count(0, 1, a0);
        idle(5);
        get_count(0, 0, b0);
        check("R4 stopped count stable", b0, a0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule